// File: doc/BRIEF.md
# Link-Status Output Gating Controller

This block sits between the recovered-video datapath of a serial-link receiver and its parallel pixel output pins. On every cycle it decides whether the colour, sync, data-enable and pixel-clock outputs carry live video, are driven low, or are released to a sleep state. The decision depends on the link lock status, a power-down input, three configuration straps captured once after power-on reset, and a software release bit that ends a hold-low start-up mode.

The block runs from a clock at twice the pixel rate and generates the outgoing pixel clock itself as a divide-by-two. This lets it launch data on whichever pixel-clock edge is opposite to the receiving edge, so a display can sample on the rising or the falling edge as strapped. The lock input is asynchronous and passes through a two-flop synchronizer. Power-down clears the synchronizer and the release bit, but it leaves the strapped options unchanged.

Top module: `link_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `out_oe` is 0 and every data, sync and clock output is 0.
- R2: `strap_in` is captured on the first clock edge after reset and then ignored until the next reset. The fields are `strap_in[0]` edge select, `strap_in[1]` sleep select and `strap_in[2]` hold-low.
- R3: `lock_in` is synchronized by two flops. The outputs become live no earlier than three edges after `lock_in` is seen high.
- R4: The outputs are live when the synchronized lock is 1, `pwr_dn` is 0, and either hold-low is clear or the release bit is set. In this state `out_oe` is 1, `out_pclk` toggles every clock, and `out_rgb`, `out_hs`, `out_vs` and `out_de` carry the captured inputs.
- R5: With hold-low clear and lock 0, sleep select 0 gives `out_oe`=0 with all outputs 0. Sleep select 1 gives `out_oe`=1 with all outputs driven 0.
- R6: While `pwr_dn` is 1, the outputs take the same sleep state as in R5, and the synchronizer and the release bit return to 0.
- R7: With hold-low set, the outputs stay driven low (`out_oe`=1, all 0), even with lock, until `rel_wr` is pulsed while `pwr_dn` is 0.
- R8: With hold-low set, sleep select is ignored. Whenever the outputs are not live, they are driven low with `out_oe`=1.
- R9: A falling edge of the synchronized lock clears the release bit. This takes priority over a write in the same cycle.
- R10: With edge select 1, the data outputs change only on edges where `out_pclk` goes to 0, so they are stable at its rising edge. With edge select 0, they change only where `out_pclk` goes to 1.
- R11: `out_pclk` is held at 0 whenever the outputs are not live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_dn | input | 1 | Power-down request, synchronous |
| lock_in | input | 1 | Asynchronous link lock status |
| strap_in | input | 3 | Configuration straps: [0] edge select, [1] sleep select, [2] hold-low |
| rel_wr | input | 1 | One-cycle write of 1 to the hold-low release bit |
| pix_rgb | input | 3*CW | Recovered colour data |
| pix_hs | input | 1 | Recovered horizontal sync |
| pix_vs | input | 1 | Recovered vertical sync |
| pix_de | input | 1 | Recovered data enable |
| out_rgb | output | 3*CW | Gated colour outputs |
| out_hs | output | 1 | Gated horizontal sync |
| out_vs | output | 1 | Gated vertical sync |
| out_de | output | 1 | Gated data enable |
| out_pclk | output | 1 | Generated pixel clock |
| out_oe | output | 1 | Pad output enable; 0 means high impedance |

## Verification
The assertions assume that `pwr_dn` and `rel_wr` are synchronous to `clk`. They also assume that `lock_in` stays stable long enough to pass through the synchronizer, so that a lock level seen at the output can be traced back three edges. The stimulus changes lock and power-down only on falling clock edges, then holds them for several cycles before the next release write or the next check. The pixel inputs are either held constant or stepped once per clock, so that the launch edge can be observed.

// File: rtl/link_gate_ctrl.sv
module link_gate_ctrl #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_dn,
  input  logic            lock_in,
  input  logic [2:0]      strap_in,
  input  logic            rel_wr,
  input  logic [3*CW-1:0] pix_rgb,
  input  logic            pix_hs,
  input  logic            pix_vs,
  input  logic            pix_de,
  output logic [3*CW-1:0] out_rgb,
  output logic            out_hs,
  output logic            out_vs,
  output logic            out_de,
  output logic            out_pclk,
  output logic            out_oe
);
  localparam int PW = 3*CW;

  typedef enum logic [1:0] {M_STRAP, M_HIZ, M_LOW, M_LIVE} mode_t;

  logic strap_q, edge_q, sleep_q, hold_q;
  logic sync1, lock_s, lock_sd, rel_q;
  logic ph_q;
  mode_t mode_q, mode_d, idle_m;
  logic [PW-1:0] rgb_q;
  logic hs_q, vs_q, de_q;
  logic lock_fall, ph_d, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= 1'b0;
      edge_q  <= 1'b0;
      sleep_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (!strap_q) begin
      strap_q <= 1'b1;
      edge_q  <= strap_in[0];
      sleep_q <= strap_in[1];
      hold_q  <= strap_in[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0; lock_s <= 1'b0; lock_sd <= 1'b0;
    end else if (pwr_dn) begin
      sync1 <= 1'b0; lock_s <= 1'b0; lock_sd <= 1'b0;
    end else begin
      sync1 <= lock_in; lock_s <= sync1; lock_sd <= lock_s;
    end
  end

  assign lock_fall = lock_sd & ~lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rel_q <= 1'b0;
    else if (pwr_dn || lock_fall) rel_q <= 1'b0;
    else if (rel_wr)              rel_q <= 1'b1;
  end

  assign idle_m = (hold_q || sleep_q) ? M_LOW : M_HIZ;

  always_comb begin
    if (!strap_q)                mode_d = M_STRAP;
    else if (pwr_dn || !lock_s)  mode_d = idle_m;
    else if (hold_q && !rel_q)   mode_d = M_LOW;
    else                         mode_d = M_LIVE;
  end

  assign ph_d = (mode_d == M_LIVE) ? ~ph_q : 1'b0;
  assign load = (mode_d == M_LIVE) && (ph_d == ~edge_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_STRAP;
      ph_q   <= 1'b0;
      rgb_q  <= '0;
      hs_q   <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ph_q   <= ph_d;
      if (mode_d != M_LIVE) begin
        rgb_q <= '0;
        hs_q  <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0;
      end else if (load) begin
        rgb_q <= pix_rgb;
        hs_q  <= pix_hs; vs_q <= pix_vs; de_q <= pix_de;
      end
    end
  end

  assign out_rgb  = rgb_q;
  assign out_hs   = hs_q;
  assign out_vs   = vs_q;
  assign out_de   = de_q;
  assign out_pclk = ph_q;
  assign out_oe   = (mode_q == M_LOW) || (mode_q == M_LIVE);

  logic live;
  assign live = (mode_q == M_LIVE);

  a_r1_strap_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_q |-> !out_oe && !out_pclk);
  a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $past(lock_in, 3));
  a_r6_pd_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_dn) && $past(strap_q) && !hold_q && !sleep_q |-> !out_oe);
  a_r7_release_needed: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && live |-> $past(rel_q));
  a_r8_hold_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q && $past(strap_q) && $past(pwr_dn || !lock_s) |-> out_oe && !out_pclk && (out_rgb == '0));
  a_r9_rel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_s) |=> !rel_q);
  a_r10_stable_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(live) && (out_pclk == edge_q) |-> $stable(out_rgb) && $stable(out_de));
  a_r11_pclk_park: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !out_pclk);
endmodule

// File: tb/link_gate_ctrl_bench.sv
module link_gate_ctrl_bench;
  localparam int CW = 8;
  localparam int PW = 3*CW;
  localparam int M_HIZ = 1, M_LOW = 2, M_LIVE = 3;

  logic clk = 0, rst_n = 0, pwr_dn = 0, lock_in = 0, rel_wr = 0;
  logic [2:0] strap_in = 0;
  logic [PW-1:0] pix_rgb = 0;
  logic pix_hs = 0, pix_vs = 0, pix_de = 0;
  logic [PW-1:0] out_rgb;
  logic out_hs, out_vs, out_de, out_pclk, out_oe;

  int n_tests = 0, n_fail = 0;
  bit m_edge, m_sleep, m_hold, m_rel, m_eff;

  always #2.5 clk = ~clk;

  link_gate_ctrl #(.CW(CW)) u_link_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .lock_in(lock_in),
    .strap_in(strap_in), .rel_wr(rel_wr), .pix_rgb(pix_rgb),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .out_rgb(out_rgb), .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de),
    .out_pclk(out_pclk), .out_oe(out_oe));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mode();
    if (!m_eff) return (m_hold || m_sleep) ? M_LOW : M_HIZ;
    if (m_hold && !m_rel) return M_LOW;
    return M_LIVE;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    int m;
    logic p0;
    m = exp_mode();
    chk(out_oe == (m != M_HIZ), {tag, " oe"}, out_oe, m != M_HIZ);
    if (m == M_LIVE) begin
      chk({out_rgb, out_hs, out_vs, out_de} == {pix_rgb, pix_hs, pix_vs, pix_de},
          {tag, " R4 live data"}, out_rgb, pix_rgb);
      p0 = out_pclk;
      cyc(1);
      chk(out_pclk == ~p0, {tag, " R4 pclk toggle"}, out_pclk, ~p0);
    end else begin
      chk({out_rgb, out_hs, out_vs, out_de, out_pclk} == '0,
          {tag, " R11 idle outputs zero"}, {out_rgb, out_pclk}, 0);
    end
  endtask

  task automatic apply(input bit lk, input bit pd, input bit wr, input string tag);
    bit ne;
    lock_in = lk; pwr_dn = pd;
    ne = lk && !pd;
    if (pd) m_rel = 0;
    else if (m_eff && !ne) m_rel = 0;
    m_eff = ne;
    cyc(6);
    if (wr) begin
      rel_wr = 1; cyc(1); rel_wr = 0;
      if (!pd) m_rel = 1;
    end
    cyc(4);
    check_state(tag);
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst_n = 0; pwr_dn = 0; lock_in = 0; rel_wr = 0; strap_in = s;
    cyc(3);
    chk(!out_oe && !out_pclk && out_rgb == '0, "R1 reset outputs", {out_oe, out_pclk}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(!out_oe, "R1 first edge hiz", out_oe, 0);
    strap_in = ~s;
    m_edge = s[0]; m_sleep = s[1]; m_hold = s[2]; m_rel = 0; m_eff = 0;
    cyc(2);
  endtask

  task automatic edge_check();
    logic [PW-1:0] prev;
    int changes;
    changes = 0;
    prev = out_rgb;
    for (int i = 0; i < 12; i++) begin
      pix_rgb = pix_rgb + 1;
      cyc(1);
      if (out_rgb != prev) begin
        changes++;
        chk(out_pclk == ~m_edge, "R10 launch edge", out_pclk, ~m_edge);
      end
      prev = out_rgb;
    end
    chk(changes == 6, "R10 one update per pixel", changes, 6);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    cyc(1);
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      pix_rgb = $urandom; pix_hs = 1; pix_vs = 0; pix_de = 1;
      apply(0, 0, 0, m_sleep && !m_hold ? "R5 unlocked sleep low" : "R5/R8 unlocked idle");
      apply(1, 0, 0, m_hold ? "R7 hold-low before release" : "R4 live after lock");
      apply(1, 0, 1, "R7 release write");
      if (exp_mode() == M_LIVE) edge_check();
      apply(0, 0, 0, "R8 lock lost");
      apply(1, 0, 0, "R9 release cleared by lock fall");
      apply(1, 1, 0, "R6 power-down sleep state");
      apply(1, 0, 0, "R6 release cleared by power-down");
      apply(0, 0, 1, "R9 write while unlocked");
      apply(1, 0, 0, "R2 straps held after write");
      for (int k = 0; k < 20; k++) begin
        pix_rgb = $urandom; pix_hs = 1'($urandom); pix_vs = 1'($urandom); pix_de = 1'($urandom);
        strap_in = 3'($urandom);
        apply(1'($urandom), ($urandom % 4) == 0, 1'($urandom), "R2/R4 random");
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule